// File: doc/BRIEF.md
# I2C Register Transfer Controller

This block is the controller side of a two-wire I2C bus. It runs complete register transactions against one addressed target. A write command sends the device address with the direction bit at 0, then one register byte, then a stream of data bytes, and ends with a STOP. A read command first sets the register pointer the same way. It then issues a repeated START and the address with the direction bit at 1, clocks in the requested number of bytes, and ends with a STOP. The bus is never released between the two phases of a read.

Each bit occupies one slot of four equal quarter periods. The quarter length comes from one of two parameterised divider settings, chosen per command, which gives standard-rate or fast-rate SCL. Both lines are open drain: an output enable high pulls the wire low. SDA is sampled through a separate input. Outgoing data bytes are taken from `wr_data` one at a time, and each one taken is marked by `wr_take`. Each received byte is presented with a one-cycle `rd_valid` strobe. A one-cycle `done` pulse with `done_err` closes every command.

Top module: `i2c_regxfer`

## Requirements
- R1: While idle, `cmd_ready` is high and both `scl_oe` and `sda_oe` are low. This is also the state after reset.
- R2: SDA changes while SCL is released only to form a START (SDA falls), a repeated START (SDA falls) or a STOP (SDA rises). Every other SDA change happens while SCL is held low.
- R3: A write command puts this on the bus: START, then the address byte `{cmd_dev, 0}`, then `cmd_reg`, then `cmd_len` data bytes, then STOP. Each byte is sent most significant bit first and is followed by a ninth acknowledge clock.
- R4: A read command with a non-zero count puts this on the bus: START, `{cmd_dev, 0}`, `cmd_reg`, repeated START, `{cmd_dev, 1}`, `cmd_len` data bytes, then STOP. There is no STOP between the two phases.
- R5: The controller drives SDA low (ACK) on the ninth clock of every received byte except the last one, which it leaves high (NACK). Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R6: When SDA is high on the acknowledge clock of any byte the controller sends (address, register or data), no further bytes are sent. The controller issues a STOP and `done_err` is 1 with `done`.
- R7: `done` is a single-cycle pulse in the cycle after the STOP completes. `done_err` is 0 on a command with no NACK. At most one of `done`, `rd_valid` and `wr_take` is high in any cycle.
- R8: `wr_take` pulses once for each data byte that is loaded from `wr_data`, so a completed write produces exactly `cmd_len` pulses. A command aborted at the address or register byte produces none.
- R9: With `cmd_fast` = 0, each SCL high time in a byte is 2×`QTR_STD` clock cycles. With `cmd_fast` = 1 it is 2×`QTR_FAST` clock cycles.
- R10: A command with `cmd_len` = 0 ends with a STOP directly after the register byte. For a read, this means no repeated START is issued.
- R11: `rd_valid` is asserted only while a read command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; a command is accepted when this and `cmd_valid` are both high |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_fast | input | 1 | 1 = fast divider, 0 = standard divider |
| cmd_dev | input | 7 | Target device address |
| cmd_reg | input | 8 | Register address byte |
| cmd_len | input | CNT_W | Number of data bytes |
| wr_data | input | 8 | Next byte to write; held until `wr_take` |
| wr_take | output | 1 | Pulse: `wr_data` has been loaded |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_data` is valid |
| done | output | 1 | Pulse: the command has finished |
| done_err | output | 1 | With `done`: a NACK aborted the command |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Four things are checked on every cycle by the assertions. The lines are released whenever the block is idle. SDA moves under a high SCL only inside a START, repeated START or STOP slot. `done` lasts one cycle and never coincides with a read or write strobe. Read strobes occur only during read commands. The remaining behaviours can only be shown by the bench scenarios, which run against a behavioural target that acknowledges or refuses bytes: the exact order of bytes and acknowledge bits on the bus, the abort paths after address and register NACKs, wrap-around of the target's register pointer, the zero-count commands, and the SCL high time at both divider settings.

// File: rtl/i2c_regxfer_pkg.sv
package i2c_regxfer_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_REG, ST_WDATA,
    ST_RSTART, ST_RADDR, ST_RDATA, ST_STOP
  } xfer_state_e;

  typedef enum logic [1:0] {
    SLOT_BIT, SLOT_START, SLOT_STOP
  } slot_kind_e;

  // reload value of the quarter-period counter
  function automatic int unsigned qtr_reload(input logic fast,
                                             input int unsigned std_q,
                                             input int unsigned fast_q);
    return (fast ? fast_q : std_q) - 1;
  endfunction

  // first byte after a (repeated) start
  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rd);
    return {dev, rd};
  endfunction

endpackage

// File: rtl/i2c_regxfer_qtick.sv
module i2c_regxfer_qtick
  import i2c_regxfer_pkg::*;
#(
  parameter int unsigned QTR_STD  = 125,
  parameter int unsigned QTR_FAST = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int unsigned CW = $clog2(QTR_STD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  assign reload = CW'(qtr_reload(fast, QTR_STD, QTR_FAST));
  assign tick   = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= reload;
    else if (cnt == '0)    cnt <= reload;
    else                   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/i2c_regxfer_shreg.sv
module i2c_regxfer_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  output logic         msb,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (load)  value <= load_val;
    else if (shift) value <= {value[W-2:0], in_bit};
  end
  assign msb = value[W-1];
endmodule

// File: rtl/i2c_regxfer.sv
module i2c_regxfer
  import i2c_regxfer_pkg::*;
#(
  parameter int unsigned QTR_STD  = 125,
  parameter int unsigned QTR_FAST = 32,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_read,
  input  logic             cmd_fast,
  input  logic [6:0]       cmd_dev,
  input  logic [7:0]       cmd_reg,
  input  logic [CNT_W-1:0] cmd_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             done_err,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int unsigned BITS_PER_BYTE = 8;
  localparam logic [3:0]  BIT_FIRST     = 4'(BITS_PER_BYTE);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

  xfer_state_e state, nxt;
  slot_kind_e  kind;
  logic [1:0]  qph;
  logic [3:0]  bitn;
  logic [CNT_W-1:0] rem;
  logic [6:0]  dev_q;
  logic [7:0]  reg_q;
  logic        rd_q, fast_q, err_q, ack_hi;
  logic        scl_low, sda_low;

  logic        tick, slot_end, byte_end, tx_state, bitv;
  logic        sh_load, sh_shift, sh_msb, take, rd_pulse, fin;
  logic [7:0]  sh_val, sh_value;

  // named events for the checker
  logic        ev_cond_slot;
  logic        ev_rd_cmd;

  i2c_regxfer_qtick #(.QTR_STD(QTR_STD), .QTR_FAST(QTR_FAST)) u_qtick (
    .clk(clk), .rst_n(rst_n),
    .run(state != ST_IDLE),
    .fast((state == ST_IDLE) ? cmd_fast : fast_q),
    .tick(tick)
  );

  i2c_regxfer_shreg #(.W(BITS_PER_BYTE)) u_shreg (
    .clk(clk), .rst_n(rst_n),
    .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .in_bit(sda_in),
    .msb(sh_msb), .value(sh_value)
  );

  always_comb begin
    unique case (state)
      ST_START, ST_RSTART: kind = SLOT_START;
      ST_STOP:             kind = SLOT_STOP;
      default:             kind = SLOT_BIT;
    endcase
  end

  assign tx_state = (state == ST_ADDR) || (state == ST_REG) ||
                    (state == ST_WDATA) || (state == ST_RADDR);
  assign slot_end = tick && (qph == 2'd3);
  assign byte_end = slot_end && (kind == SLOT_BIT) && (bitn == 4'd0);
  assign sh_shift = tick && (qph == 2'd2) && (kind == SLOT_BIT) && (bitn != 4'd0);
  // level wanted on SDA during a bit slot (1 = released)
  assign bitv = (state == ST_RDATA) ? ((bitn != 4'd0) ? 1'b1 : (rem == ONE_LEFT))
                                    : ((bitn != 4'd0) ? sh_msb : 1'b1);

  always_comb begin
    nxt      = state;
    sh_load  = 1'b0;
    sh_val   = 8'h00;
    take     = 1'b0;
    rd_pulse = 1'b0;
    fin      = 1'b0;
    if (state == ST_IDLE) begin
      if (cmd_valid) nxt = ST_START;
    end else if (slot_end) begin
      unique case (state)
        ST_START: begin
          nxt = ST_ADDR; sh_load = 1'b1; sh_val = addr_byte(dev_q, 1'b0);
        end
        ST_RSTART: begin
          nxt = ST_RADDR; sh_load = 1'b1; sh_val = addr_byte(dev_q, 1'b1);
        end
        ST_STOP: begin
          nxt = ST_IDLE; fin = 1'b1;
        end
        default: begin
          if (bitn == 4'd0) begin
            if (tx_state && ack_hi) nxt = ST_STOP;
            else begin
              unique case (state)
                ST_ADDR: begin nxt = ST_REG; sh_load = 1'b1; sh_val = reg_q; end
                ST_REG: begin
                  if (rem == '0)  nxt = ST_STOP;
                  else if (rd_q)  nxt = ST_RSTART;
                  else begin
                    nxt = ST_WDATA; sh_load = 1'b1; sh_val = wr_data; take = 1'b1;
                  end
                end
                ST_WDATA: begin
                  if (rem == ONE_LEFT) nxt = ST_STOP;
                  else begin sh_load = 1'b1; sh_val = wr_data; take = 1'b1; end
                end
                ST_RADDR: nxt = ST_RDATA;
                ST_RDATA: begin
                  rd_pulse = 1'b1;
                  if (rem == ONE_LEFT) nxt = ST_STOP;
                end
                default: nxt = ST_STOP;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      qph      <= 2'd0;
      bitn     <= BIT_FIRST;
      rem      <= '0;
      dev_q    <= '0;
      reg_q    <= '0;
      rd_q     <= 1'b0;
      fast_q   <= 1'b0;
      err_q    <= 1'b0;
      ack_hi   <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      state    <= nxt;
      wr_take  <= take;
      rd_valid <= rd_pulse;
      done     <= fin;
      done_err <= fin && err_q;
      if (rd_pulse) rd_data <= sh_value;
      if (state == ST_IDLE && cmd_valid) begin
        dev_q  <= cmd_dev;
        reg_q  <= cmd_reg;
        rd_q   <= cmd_read;
        fast_q <= cmd_fast;
        rem    <= cmd_len;
        err_q  <= 1'b0;
        qph    <= 2'd0;
        bitn   <= BIT_FIRST;
      end
      if (tick) begin
        qph <= qph + 2'd1;
        unique case (qph)
          2'd0: sda_low <= (kind == SLOT_START) ? 1'b0 :
                           (kind == SLOT_STOP)  ? 1'b1 : !bitv;
          2'd1: scl_low <= 1'b0;
          2'd2: begin
            if (kind == SLOT_START)     sda_low <= 1'b1;
            else if (kind == SLOT_STOP) sda_low <= 1'b0;
            else if (bitn == 4'd0)      ack_hi  <= sda_in;
          end
          default: if (kind != SLOT_STOP) scl_low <= 1'b1;
        endcase
      end
      if (slot_end && kind == SLOT_BIT)
        bitn <= (bitn == 4'd0) ? BIT_FIRST : bitn - 4'd1;
      if (byte_end && tx_state && ack_hi) err_q <= 1'b1;
      if (byte_end && (state == ST_WDATA || state == ST_RDATA)) rem <= rem - 1'b1;
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign scl_oe       = scl_low;
  assign sda_oe       = sda_low;
  assign ev_cond_slot = (kind != SLOT_BIT);
  assign ev_rd_cmd    = rd_q;
endmodule

// File: rtl/i2c_regxfer_chk.sv
module i2c_regxfer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic rd_valid,
  input logic wr_take,
  input logic cond_slot,
  input logic rd_cmd
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!scl_oe && !sda_oe));

  // SDA may only move under a released SCL inside a start/stop slot
  assert_sda_under_high_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> $past(cond_slot));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, rd_valid, wr_take}));

  assert_done_bus_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_oe && !sda_oe));

  assert_read_strobe_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_cmd);
endmodule

bind i2c_regxfer i2c_regxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done),
  .rd_valid(rd_valid), .wr_take(wr_take),
  .cond_slot(ev_cond_slot), .rd_cmd(ev_rd_cmd)
);

// File: tb/i2c_regxfer_bench.sv
module i2c_regxfer_bench;
  localparam int QS = 6;
  localparam int QF = 3;
  localparam logic [6:0] TGT = 7'h2A;
  localparam int EV_S = 'h1000;
  localparam int EV_P = 'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_fast = 1'b0;
  logic [6:0] cmd_dev = '0;
  logic [7:0] cmd_reg = '0, cmd_len = '0, wr_data = '0;
  logic cmd_ready, wr_take, rd_valid, done, done_err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic tgt_low = 1'b0;
  wire  scl_bus = !scl_oe;
  wire  sda_bus = !(sda_oe || tgt_low);

  always #2 clk = ~clk;

  i2c_regxfer #(.QTR_STD(QS), .QTR_FAST(QF), .CNT_W(8)) u_i2c_regxfer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_fast(cmd_fast), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_len(cmd_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .done_err(done_err), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int errs = 0, checks = 0, cyc = 0;
  int exp_q[$];
  int rd_exp[$];
  logic [7:0] wq[$];
  logic [7:0] ref_mem[16];
  logic [7:0] tmem[16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural target and bus observer
  int bitc = 0, bidx = 0, rise_t = 0, takes = 0, rds = 0, dones = 0;
  bit addressed = 0, rmode = 0, last_ack = 1, sending = 0, have_rise = 0, fast_now = 0;
  bit prev_scl = 1, prev_sda = 1, last_err = 0;
  logic [7:0] sh = '0, txb = '0, ptr = '0;

  task automatic observe(input int v);
    int front;
    front = (exp_q.size() > 0) ? exp_q[0] : -1;
    chk(front == v, "R2 R3 R4 bus sequence", v, front);
    if (exp_q.size() > 0) void'(exp_q.pop_front());
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit cs, cd;
      cs = scl_bus; cd = sda_bus;
      cyc++;
      if (cs && prev_scl && prev_sda && !cd) begin
        observe(EV_S); bitc = 0; bidx = 0; sending = 0; tgt_low = 1'b0; have_rise = 0;
      end else if (cs && prev_scl && !prev_sda && cd) begin
        observe(EV_P); bitc = 0; sending = 0; tgt_low = 1'b0;
      end
      if (cs && !prev_scl) begin
        rise_t = cyc; have_rise = 1;
        if (bitc < 8) sh = {sh[6:0], cd};
        else begin observe({sh, cd}); last_ack = cd; end
        bitc++;
      end
      if (!cs && prev_scl) begin
        if (have_rise)
          chk(cyc - rise_t == 2 * (fast_now ? QF : QS), "R9 SCL high time",
              cyc - rise_t, 2 * (fast_now ? QF : QS));
        have_rise = 0;
        if (bitc == 8) begin
          if (bidx == 0) begin
            addressed = (sh[7:1] == TGT); rmode = sh[0]; tgt_low = addressed;
          end else if (addressed && !rmode) begin
            if (bidx == 1) begin ptr = sh; tgt_low = (sh < 8'd16); end
            else begin tmem[ptr[3:0]] = sh; ptr++; tgt_low = 1'b1; end
          end else tgt_low = 1'b0;
        end else if (bitc == 9) begin
          tgt_low = 1'b0; bitc = 0;
          if (addressed && rmode && (bidx == 0 || last_ack == 0)) begin
            txb = tmem[ptr[3:0]]; ptr++;
            tgt_low = !txb[7]; txb = {txb[6:0], 1'b0}; sending = 1;
          end else sending = 0;
          bidx++;
        end else if (sending && bitc > 0 && bitc < 8) begin
          tgt_low = !txb[7]; txb = {txb[6:0], 1'b0};
        end
      end
      prev_scl = cs; prev_sda = cd;
      if (wr_take) begin
        takes++;
        if (wq.size() > 0) void'(wq.pop_front());
        wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
      end
      if (rd_valid) begin
        int e;
        e = (rd_exp.size() > 0) ? int'(rd_exp[0]) : -1;
        chk(int'(rd_data) == e, "R5 read byte", rd_data, e);
        rds++;
        if (rd_exp.size() > 0) void'(rd_exp.pop_front());
      end
      if (done) begin dones++; last_err = done_err; end
    end
  end

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary_and_end();
  end

  // builds the expected bus events from the requirements and runs one command
  task automatic run_cmd(input bit rd, input bit fast, input logic [6:0] dev,
                         input logic [7:0] rg, input int len, input string tag);
    bit exp_err;
    int exp_takes, d0, t0, r0, exp_rds;
    exp_err = 0; exp_takes = 0; exp_rds = 0;
    exp_q.push_back(EV_S);
    exp_q.push_back({dev, 1'b0, (dev != TGT)});
    if (dev != TGT) exp_err = 1;
    else begin
      exp_q.push_back({rg, (rg >= 8'd16)});
      if (rg >= 8'd16) exp_err = 1;
      else if (len != 0 && !rd) begin
        for (int i = 0; i < len; i++) begin
          exp_q.push_back({wq[i], 1'b0});
          ref_mem[(int'(rg) + i) % 16] = wq[i];
        end
        exp_takes = len;
      end else if (len != 0) begin
        exp_q.push_back(EV_S);
        exp_q.push_back({dev, 1'b1, 1'b0});
        for (int i = 0; i < len; i++) begin
          logic [7:0] v;
          v = ref_mem[(int'(rg) + i) % 16];
          exp_q.push_back({v, (i == len - 1)});
          rd_exp.push_back(v);
        end
        exp_rds = len;
      end
    end
    exp_q.push_back(EV_P);
    d0 = dones; t0 = takes; r0 = rds;
    @(negedge clk);
    fast_now = fast;
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    cmd_read = rd; cmd_fast = fast; cmd_dev = dev; cmd_reg = rg; cmd_len = 8'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (dones == d0) @(negedge clk);
    chk(last_err == exp_err, {tag, " R6 R7 done_err"}, last_err, exp_err);
    chk(exp_q.size() == 0, {tag, " R2 all bus events seen"}, exp_q.size(), 0);
    chk(takes - t0 == exp_takes, {tag, " R8 wr_take count"}, takes - t0, exp_takes);
    chk(rds - r0 == exp_rds, {tag, " R5 rd_valid count"}, rds - r0, exp_rds);
    @(negedge clk);
    chk(dones - d0 == 1, {tag, " R7 single done"}, dones - d0, 1);
    chk(cmd_ready && !scl_oe && !sda_oe, {tag, " R1 idle after done"},
        {cmd_ready, scl_oe, sda_oe}, 3'b100);
    exp_q.delete(); rd_exp.delete(); wq.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ref_mem[i] = 8'(i * 17 + 1);
      tmem[i]    = 8'(i * 17 + 1);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !scl_oe && !sda_oe, "R1 reset state",
        {cmd_ready, scl_oe, sda_oe}, 3'b100);
    // R3 R8: write two bytes, standard rate
    wq.push_back(8'hA5); wq.push_back(8'h3C);
    run_cmd(1'b0, 1'b0, TGT, 8'd3, 2, "write2");
    // R4 R5 R9: read three bytes with repeated start, fast rate
    run_cmd(1'b1, 1'b1, TGT, 8'd3, 3, "read3");
    // R6: wrong device address, abort with no byte taken
    wq.push_back(8'h77);
    run_cmd(1'b0, 1'b0, 7'h11, 8'd1, 1, "addr_nack");
    // R6: register byte refused by the target
    run_cmd(1'b1, 1'b1, TGT, 8'd20, 2, "reg_nack");
    // R5: single read byte is NACKed at once
    run_cmd(1'b1, 1'b1, TGT, 8'd0, 1, "read1");
    // R10: zero-count write and read
    run_cmd(1'b0, 1'b0, TGT, 8'd7, 0, "write0");
    run_cmd(1'b1, 1'b0, TGT, 8'd7, 0, "read0");
    // R3 R4: pointer wrap in the target, write then read back
    wq.push_back(8'h11); wq.push_back(8'h22);
    run_cmd(1'b0, 1'b1, TGT, 8'd15, 2, "write_wrap");
    run_cmd(1'b1, 1'b0, TGT, 8'd15, 2, "read_wrap");
    summary_and_end();
  end
endmodule